// File: doc/BRIEF.md
# Interrupt Set/Clear Register Block

This block collects thirteen single-cycle event pulses from a serial port into sticky pending bits and raises one interrupt line when any pending bit is also enabled. Software programs the enables only through two write-only strobe registers. Ones written to the enable register turn those sources on. Ones written to the disable register turn them off. A separate read-only register shows the current enable set. Because setting and clearing go through different addresses, two pieces of software can change different sources without a read-modify-write race.

A pending bit is cleared by writing a one to its position in the status register. An event that arrives in the same cycle as that clear keeps the bit set, so no event is lost. The register bus is a plain single-cycle interface. A write is taken on the rising clock edge while the write strobe is high. Read data is a combinational decode of the current address.

Top module: `irq_setclr_regs`

## Requirements
- R1: After reset, the enable mask and every pending bit read as zero and `irq_o` is low.
- R2: A write to offset 0x08 sets each mask bit whose write-data bit is 1 and leaves every other mask bit unchanged. The mask reads back at offset 0x10 in bits 12:0.
- R3: A write to offset 0x0C clears each mask bit whose write-data bit is 1 and leaves every other mask bit unchanged.
- R4: A high on `event_i[k]` sets pending bit k at the next clock edge, and the bit stays set after the pulse ends. The pending bits read back at offset 0x14. Source k maps to bit k: 0 receive threshold, 1 receive empty, 2 receive full, 3 transmit empty, 4 transmit full, 5 receive overrun, 6 framing error, 7 parity error, 8 receive idle timeout, 9 line-status change, 10 transmit threshold, 11 transmit almost full, 12 transmit overrun.
- R5: A write to offset 0x14 clears each pending bit whose write-data bit is 1. Write-data bits that are 0 leave the corresponding pending bits unchanged.
- R6: When an event on bit k arrives in the same cycle as a clear of bit k, pending bit k stays set.
- R7: `irq_o` is high exactly when some bit is both pending and enabled. An event on a disabled source sets its pending bit but does not raise `irq_o`.
- R8: Reads of offsets 0x08 and 0x0C, reads of any unmapped offset, and read-data bits 31:13 always return zero.
- R9: A write to the read-only mask offset 0x10, or to an unmapped offset, changes neither the mask nor the pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Byte offset of the register being accessed |
| wr_en_i | input | 1 | Write strobe, taken at the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| event_i | input | 13 | One-cycle event pulses, one bit per source |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: 13 sources, a 32-bit data bus and a 6-bit offset. With these values every source position can be driven, including the all-sources value 0x1FFF. The bench can also check that write-data bits 31:13 set nothing and that the corresponding read-data bits stay zero. It also covers a clear and an event on the same bit in the same cycle, and writes to the read-only and unmapped offsets.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NUM_SRC = 13;

  // source positions; software decodes these
  typedef enum int unsigned {
    SRC_RX_THR    = 0,
    SRC_RX_EMPTY  = 1,
    SRC_RX_FULL   = 2,
    SRC_TX_EMPTY  = 3,
    SRC_TX_FULL   = 4,
    SRC_RX_OVR    = 5,
    SRC_FRAME     = 6,
    SRC_PARITY    = 7,
    SRC_RX_IDLE   = 8,
    SRC_LINE_CHG  = 9,
    SRC_TX_THR    = 10,
    SRC_TX_AFULL  = 11,
    SRC_TX_OVR    = 12
  } irq_src_e;

  typedef struct packed {
    logic en_hit;
    logic dis_hit;
    logic stat_hit;
  } wr_dec_t;
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned N = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_o <= '0;
    else         mask_o <= (mask_o | set_i) & ~clr_i;
  end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int unsigned N = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] stat_o
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       stat_o[k] <= 1'b0;
      else if (evt_i[k]) stat_o[k] <= 1'b1;  // event beats clear
      else if (clr_i[k]) stat_o[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux #(
  parameter int unsigned N      = 13,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] OFF_MASK = 'h10,
  parameter logic [ADDR_W-1:0] OFF_STAT = 'h14
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      mask_i,
  input  logic [N-1:0]      stat_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (addr_i == OFF_MASK)      rdata_o[N-1:0] = mask_i;
    else if (addr_i == OFF_STAT) rdata_o[N-1:0] = stat_i;
  end
endmodule

// File: rtl/irq_setclr_regs.sv
module irq_setclr_regs #(
  parameter int unsigned NUM_SRC = irq_pkg::NUM_SRC,
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned DATA_W  = 32,
  parameter logic [ADDR_W-1:0] OFF_EN   = 'h08,
  parameter logic [ADDR_W-1:0] OFF_DIS  = 'h0C,
  parameter logic [ADDR_W-1:0] OFF_MASK = 'h10,
  parameter logic [ADDR_W-1:0] OFF_STAT = 'h14
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [NUM_SRC-1:0] event_i,
  output logic               irq_o
);
  import irq_pkg::*;

  wr_dec_t            dec;
  logic [NUM_SRC-1:0] wbits, set_v, dis_v, clr_v;
  logic [NUM_SRC-1:0] mask_q, stat_q;
  logic               unused_hi;

  assign wbits     = wdata_i[NUM_SRC-1:0];
  assign unused_hi = ^wdata_i[DATA_W-1:NUM_SRC];

  assign dec.en_hit   = wr_en_i && (addr_i == OFF_EN);
  assign dec.dis_hit  = wr_en_i && (addr_i == OFF_DIS);
  assign dec.stat_hit = wr_en_i && (addr_i == OFF_STAT);

  assign set_v = dec.en_hit   ? wbits : '0;
  assign dis_v = dec.dis_hit  ? wbits : '0;
  assign clr_v = dec.stat_hit ? wbits : '0;

  irq_mask_reg #(.N(NUM_SRC)) u_mask (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .set_i (set_v), .clr_i (dis_v), .mask_o(mask_q)
  );

  irq_status_reg #(.N(NUM_SRC)) u_stat (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .evt_i (event_i), .clr_i(clr_v), .stat_o(stat_q)
  );

  irq_rd_mux #(
    .N(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .OFF_MASK(OFF_MASK), .OFF_STAT(OFF_STAT)
  ) u_rd (
    .addr_i(addr_i), .mask_i(mask_q), .stat_i(stat_q), .rdata_o(rdata_o)
  );

  assign irq_o = |(stat_q & mask_q);
endmodule

// File: rtl/irq_setclr_regs_chk.sv
module irq_setclr_regs_chk #(
  parameter int unsigned NUM_SRC = 13,
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned DATA_W  = 32,
  parameter logic [ADDR_W-1:0] OFF_EN   = 'h08,
  parameter logic [ADDR_W-1:0] OFF_DIS  = 'h0C,
  parameter logic [ADDR_W-1:0] OFF_STAT = 'h14
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               wr_en_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [NUM_SRC-1:0] event_i,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [NUM_SRC-1:0] stat_q
);
  // R2
  en_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_EN) |=>
      ((mask_q & $past(wdata_i[NUM_SRC-1:0])) == $past(wdata_i[NUM_SRC-1:0])));

  // R3
  dis_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_DIS) |=> ((mask_q & $past(wdata_i[NUM_SRC-1:0])) == '0));

  // R4 and R6: every pulsed source is pending one cycle later
  event_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_i != '0) |=> ((stat_q & $past(event_i)) == $past(event_i)));

  // R5
  w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_STAT) |=>
      ((stat_q & $past(wdata_i[NUM_SRC-1:0] & ~event_i)) == '0));

  // R7
  irq_needs_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((stat_q != '0) && (mask_q != '0)));

  // R9
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && (addr_i == OFF_EN || addr_i == OFF_DIS)) |=> $stable(mask_q));
endmodule

bind irq_setclr_regs irq_setclr_regs_chk #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .OFF_EN(OFF_EN), .OFF_DIS(OFF_DIS), .OFF_STAT(OFF_STAT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .wdata_i(wdata_i), .event_i(event_i), .irq_o(irq_o),
  .mask_q(mask_q), .stat_q(stat_q)
);

// File: tb/irq_setclr_regs_tb.sv
module irq_setclr_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 13;
  localparam int AW = 6;
  localparam int DW = 32;

  typedef struct {
    logic [DW-1:0] rdata;
    logic          irq;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [N-1:0]  ev = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  int total = 0;
  int bad = 0;
  bit done = 0;
  exp_t exp_q[$];
  logic [N-1:0] m_mask = '0;
  logic [N-1:0] m_stat = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_setclr_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .event_i(ev), .irq_o(irq)
  );

  // driver: one command per cycle, expected values from the register model
  task automatic cyc(input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d,
                     input logic [N-1:0] e, input string tag);
    exp_t it;
    @(negedge clk);
    addr = a; wr = w; wdata = d; ev = e;
    it.rdata = '0;
    if (a == 6'h10) it.rdata[N-1:0] = m_mask;
    else if (a == 6'h14) it.rdata[N-1:0] = m_stat;
    it.irq = |(m_stat & m_mask);
    it.tag = tag;
    exp_q.push_back(it);
    if (w && a == 6'h08) m_mask = m_mask | d[N-1:0];
    if (w && a == 6'h0C) m_mask = m_mask & ~d[N-1:0];
    if (w && a == 6'h14) m_stat = m_stat & ~d[N-1:0];
    m_stat = m_stat | e;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        total++;
        if (rdata !== it.rdata) begin
          bad++;
          $display("FAIL %s rdata act=%h exp=%h", it.tag, rdata, it.rdata);
        end
        total++;
        if (irq !== it.irq) begin
          bad++;
          $display("FAIL %s irq act=%b exp=%b", it.tag, irq, it.irq);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(6'h10, 0, 0, 0, "R1 mask");
    cyc(6'h14, 0, 0, 13'h0009, "R1 stat");
    cyc(6'h14, 0, 0, 0, "R4 sticky");
    cyc(6'h14, 0, 0, 0, "R7 masked source");
    cyc(6'h08, 1, 32'h0000_0008, 0, "R8 en reads zero");
    cyc(6'h10, 0, 0, 0, "R2 mask set");
    cyc(6'h08, 1, 32'h0000_1001, 0, "R2 set more");
    cyc(6'h10, 0, 0, 0, "R2 zeros kept");
    cyc(6'h14, 1, 32'h0000_0001, 0, "R5 w1c");
    cyc(6'h14, 1, 32'h0000_0000, 0, "R5 cleared one");
    cyc(6'h14, 1, 32'h0000_0008, 13'h0008, "R5 zero write");
    cyc(6'h14, 0, 0, 0, "R6 event wins");
    cyc(6'h10, 1, 32'h0000_0000, 0, "R9 mask write");
    cyc(6'h30, 1, 32'hFFFF_FFFF, 0, "R9 unmapped write");
    cyc(6'h10, 0, 0, 0, "R9 mask kept");
    cyc(6'h0C, 1, 32'h0000_0008, 0, "R8 dis reads zero");
    cyc(6'h10, 0, 0, 0, "R3 disable");
    cyc(6'h14, 0, 0, 0, "R7 irq low");
    cyc(6'h30, 0, 0, 13'h1FFF, "R8 unmapped");
    cyc(6'h14, 0, 0, 0, "R4 all sources");
    cyc(6'h14, 1, 32'hFFFF_FFFF, 0, "R7 irq high");
    cyc(6'h14, 0, 0, 13'h1000, "R5 clear all");
    cyc(6'h08, 1, 32'hFFFF_FFFF, 0, "R7 tx ovr pending");
    cyc(6'h10, 0, 0, 0, "R8 upper zero");
    cyc(6'h0C, 1, 32'hFFFF_FFFF, 0, "R2 all on");
    cyc(6'h10, 0, 0, 0, "R3 all off");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule